// File: doc/BRIEF.md
# Packet Transmit Framer

This block turns a payload waiting in a transmit FIFO into the complete byte stream a sub-GHz modulator sends on air. Whenever the radio is in transmit mode the output is never silent. Until a packet is ready, and again after it ends, the block sends filler bytes of 0xAA. Once the FIFO fill meets the selected start condition, the block always finishes the filler byte on offer. It then sends the framed packet in this order:

1. a programmed run of 0xAA preamble bytes;
2. a 1 to 4 byte sync word;
3. the payload read from the FIFO;
4. an optional CRC-16.

A parameter can remove the optional whitening stage. A configuration bit selects it at run time. It scrambles only the payload and CRC bytes.

The output is a valid/ready byte stream. The producer side is a FIFO head with `fifo_valid`/`fifo_ready`. Back-pressure rules:

- A byte on the output is accepted only on a cycle with both `out_valid` and `out_ready` high.
- While a byte waits, neither it nor `out_valid` changes.
- During the payload, `fifo_ready` follows `out_ready` combinationally, so the FIFO head is popped exactly on the cycle its byte is accepted.
- When the FIFO is empty mid-payload, `out_valid` drops until data arrives.

Leaving transmit mode aborts any frame. To send a new packet, leave transmit mode and enter it again.

Top module: `pkt_tx_framer`

## Requirements
- R1: While `tx_mode` is low (and after reset) `out_valid`, `fifo_ready` and `tx_done` are low, and no FIFO byte is consumed, even if the FIFO holds data.
- R2: In transmit mode, before the start condition is met, every output byte is 0xAA and the FIFO is not read.
- R3: With `start_any` high the start condition is "FIFO count is at least 1"; with it low it is "FIFO count is at least `start_level`"; the condition is tested only at the acceptance of a filler byte.
- R4: The filler byte on offer when the condition is met is always sent in full: with the FIFO already filled on entry to transmit mode, exactly `pre_len`+1 bytes of 0xAA precede the sync word.
- R5: The sync word is `sync_sz`+1 bytes taken from the top of `sync_word`, most significant byte first, never whitened.
- R6: With `var_len` high the first FIFO byte L is a length byte and L+1 bytes are read in total; with it low `fixed_len` bytes are read (0 means 256). No other FIFO byte is read for the packet.
- R7: With `crc_en` high two CRC bytes follow the payload: CRC-16 with polynomial 0x1021 and seed 0xFFFF, fed MSB first with the unwhitened payload bytes (length byte included), high byte sent first. With it low nothing follows the payload.
- R8: With `white_en` high each payload and CRC byte is XORed with a mask from a 9-bit register seeded to all ones at packet start. The mask is bits 7..0 of that register. After each such byte the register steps eight times. One step shifts right and loads bit0 XOR bit5 into bit 8.
- R9: `tx_done` rises the cycle after the last frame byte is accepted, stays high while `tx_mode` stays high, and from then on the output is 0xAA filler with no FIFO reads.
- R10: A byte offered but not accepted stays unchanged with `out_valid` high on the next cycle; a FIFO pop happens only together with an accepted output byte.
- R11: Dropping `tx_mode` returns the block to idle on the next clock: `out_valid` and `tx_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_mode | input | 1 | High while the radio is in transmit mode |
| start_any | input | 1 | Start selection: 1 = one byte suffices, 0 = threshold |
| start_level | input | CNT_W | FIFO count threshold when `start_any` is low |
| pre_len | input | 8 | Number of programmed preamble bytes (0 allowed) |
| sync_sz | input | SIDX_W | Sync word length minus one, in bytes |
| sync_word | input | 8*SYNC_MAX | Sync word, used from the top byte down |
| var_len | input | 1 | 1 = length byte leads the payload, 0 = fixed length |
| fixed_len | input | 8 | Payload length in fixed mode (0 means 256) |
| crc_en | input | 1 | Append CRC-16 |
| white_en | input | 1 | Whiten payload and CRC bytes |
| fifo_data | input | 8 | FIFO head byte |
| fifo_valid | input | 1 | FIFO head is valid |
| fifo_count | input | CNT_W | Bytes held in the FIFO |
| fifo_ready | output | 1 | Pop the FIFO head this cycle |
| out_data | output | 8 | Byte to the modulator |
| out_valid | output | 1 | `out_data` is valid |
| out_ready | input | 1 | Modulator takes the byte this cycle |
| tx_done | output | 1 | Packet finished |

## Verification
Each acceptance of an output byte lands on a clock edge. The bench samples `out_valid`, `out_ready` and `out_data` 1 ns after the falling edge, once the inputs it drives at that edge have settled. It records a byte exactly when both handshake bits are high, so the recorded stream is the stream the next rising edge takes.

State changes caused by an acceptance show at the next sample. This applies to `tx_done` after the last frame byte (R9) and to idle one cycle after `tx_mode` falls (R11). The bench therefore compares the stream length held when `tx_done` is first seen against its computed frame length. It checks the idle outputs two samples after the drop.

The FIFO model pops at the rising edge after a sample that saw a pop. Payload bytes therefore feed the CRC in the same cycle they leave.

// File: rtl/ptf_pkg.sv
package ptf_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_FILL, S_PRE, S_SYNC, S_PAY, S_CRC, S_DONE
  } ptf_state_e;

  localparam logic [7:0] FILL_BYTE = 8'hAA;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [8:0]  PN9_SEED = 9'h1FF;

  function automatic logic [15:0] crc_next(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [8:0] pn9_adv8(input logic [8:0] s);
    logic [8:0] r;
    r = s;
    for (int i = 0; i < 8; i++) r = {r[0] ^ r[5], r[8:1]};
    return r;
  endfunction

endpackage

// File: rtl/ptf_seq.sv
module ptf_seq
  import ptf_pkg::*;
#(
  parameter int SIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_mode,
  input  logic              accept,
  input  logic              start_hit,
  input  logic [7:0]        pre_len,
  input  logic [SIDX_W-1:0] sync_sz,
  input  logic              var_len,
  input  logic [7:0]        fixed_len,
  input  logic              crc_en,
  input  logic [7:0]        head_byte,
  output ptf_state_e        state,
  output logic [7:0]        cnt,
  output logic              pkt_init
);

  logic [7:0] pay_left;
  logic       pay_first;
  logic [7:0] first_left;
  logic       pay_end;

  assign pkt_init   = (state == S_FILL) && accept && start_hit;
  assign first_left = var_len ? head_byte : (fixed_len - 8'd1);
  assign pay_end    = pay_first ? (first_left == 8'd0) : (pay_left == 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      pay_left  <= '0;
      pay_first <= 1'b0;
    end else if (!tx_mode) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: state <= S_FILL;
        S_FILL: if (pkt_init) begin
          state <= (pre_len != 8'd0) ? S_PRE : S_SYNC;
          cnt   <= '0;
        end
        S_PRE: if (accept) begin
          if (cnt == pre_len - 8'd1) begin
            state <= S_SYNC;
            cnt   <= '0;
          end else cnt <= cnt + 8'd1;
        end
        S_SYNC: if (accept) begin
          if (cnt == 8'(sync_sz)) begin
            state     <= S_PAY;
            pay_first <= 1'b1;
            cnt       <= '0;
          end else cnt <= cnt + 8'd1;
        end
        S_PAY: if (accept) begin
          pay_first <= 1'b0;
          if (pay_end) begin
            state <= crc_en ? S_CRC : S_DONE;
            cnt   <= '0;
          end else if (pay_first) pay_left <= first_left;
          else pay_left <= pay_left - 8'd1;
        end
        S_CRC: if (accept) begin
          if (cnt == 8'd1) state <= S_DONE;
          else cnt <= 8'd1;
        end
        default: state <= S_DONE;
      endcase
    end
  end

  // R4: programmed preamble is only ever entered from a completed filler byte
  p_pre_after_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PRE && $past(state) != S_PRE) |-> $past(state) == S_FILL);

  // R6: payload section is only entered after the sync word
  p_pay_after_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PAY && $past(state) != S_PAY) |-> $past(state) == S_SYNC);

endmodule

// File: rtl/ptf_crc16.sv
module ptf_crc16
  import ptf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= CRC_SEED;
    else if (init) crc <= CRC_SEED;
    else if (en)   crc <= crc_next(crc, din);
  end

endmodule

// File: rtl/ptf_whiten.sv
module ptf_whiten
  import ptf_pkg::*;
#(
  parameter bit DC_FREE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       adv,
  input  logic       enable,
  output logic [7:0] mask
);

  generate
    if (DC_FREE) begin : g_pn9
      logic [8:0] lfsr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    lfsr <= PN9_SEED;
        else if (init) lfsr <= PN9_SEED;
        else if (adv)  lfsr <= pn9_adv8(lfsr);
      end
      assign mask = enable ? lfsr[7:0] : 8'h00;
    end else begin : g_bypass
      assign mask = 8'h00;
    end
  endgenerate

endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
  import ptf_pkg::*;
#(
  parameter int SYNC_MAX = 4,
  parameter int CNT_W    = 8,
  parameter bit DC_FREE  = 1'b1,
  localparam int SIDX_W  = (SYNC_MAX > 1) ? $clog2(SYNC_MAX) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_mode,
  input  logic                  start_any,
  input  logic [CNT_W-1:0]      start_level,
  input  logic [7:0]            pre_len,
  input  logic [SIDX_W-1:0]     sync_sz,
  input  logic [8*SYNC_MAX-1:0] sync_word,
  input  logic                  var_len,
  input  logic [7:0]            fixed_len,
  input  logic                  crc_en,
  input  logic                  white_en,
  input  logic [7:0]            fifo_data,
  input  logic                  fifo_valid,
  input  logic [CNT_W-1:0]      fifo_count,
  output logic                  fifo_ready,
  output logic [7:0]            out_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  tx_done
);

  ptf_state_e  state;
  logic [7:0]  cnt;
  logic        pkt_init;
  logic        accept;
  logic        start_hit;
  logic [15:0] crc;
  logic [7:0]  wmask;
  logic [7:0]  sync_byte;

  assign accept    = out_valid && out_ready;
  assign start_hit = start_any ? (fifo_count != '0) : (fifo_count >= start_level);

  ptf_seq #(.SIDX_W(SIDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .accept(accept),
    .start_hit(start_hit), .pre_len(pre_len), .sync_sz(sync_sz),
    .var_len(var_len), .fixed_len(fixed_len), .crc_en(crc_en),
    .head_byte(fifo_data), .state(state), .cnt(cnt), .pkt_init(pkt_init)
  );

  ptf_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .init(pkt_init),
    .en(state == S_PAY && accept), .din(fifo_data), .crc(crc)
  );

  ptf_whiten #(.DC_FREE(DC_FREE)) u_wht (
    .clk(clk), .rst_n(rst_n), .init(pkt_init),
    .adv(accept && (state == S_PAY || state == S_CRC)),
    .enable(white_en), .mask(wmask)
  );

  always_comb begin
    sync_byte = 8'h00;
    for (int k = 0; k < SYNC_MAX; k++)
      if (cnt[SIDX_W-1:0] == SIDX_W'(k)) sync_byte = sync_word[8*(SYNC_MAX-1-k) +: 8];
  end

  always_comb begin
    out_valid = 1'b1;
    out_data  = FILL_BYTE;
    case (state)
      S_IDLE: begin out_valid = 1'b0; out_data = 8'h00; end
      S_SYNC: out_data = sync_byte;
      S_PAY:  begin out_valid = fifo_valid; out_data = fifo_data ^ wmask; end
      S_CRC:  out_data = ((cnt == 8'd0) ? crc[15:8] : crc[7:0]) ^ wmask;
      default: out_data = FILL_BYTE;
    endcase
  end

  assign fifo_ready = (state == S_PAY) && out_ready;
  assign tx_done    = (state == S_DONE);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mode |=> (!out_valid && !tx_done && !fifo_ready));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && tx_mode) |=> (out_valid && $stable(out_data)));

  p_pop_with_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ready && fifo_valid) |-> accept);

  p_done_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!fifo_ready && out_valid && out_data == FILL_BYTE));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && tx_mode) |=> tx_done);

  p_leave_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_mode) |-> !tx_done || $past(tx_done));

endmodule

// File: tb/pkt_tx_framer_tb_top.sv
module pkt_tx_framer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_mode = 1'b0;
  logic        start_any = 1'b1;
  logic [7:0]  start_level = 8'd1;
  logic [7:0]  pre_len = 8'd2;
  logic [1:0]  sync_sz = 2'd1;
  logic [31:0] sync_word = 32'h2DD4_1234;
  logic        var_len = 1'b0;
  logic [7:0]  fixed_len = 8'd4;
  logic        crc_en = 1'b0;
  logic        white_en = 1'b0;
  logic [7:0]  fifo_data;
  logic        fifo_valid;
  logic [7:0]  fifo_count;
  logic        fifo_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        tx_done;

  always #5 clk = ~clk;

  pkt_tx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .start_any(start_any),
    .start_level(start_level), .pre_len(pre_len), .sync_sz(sync_sz),
    .sync_word(sync_word), .var_len(var_len), .fixed_len(fixed_len),
    .crc_en(crc_en), .white_en(white_en), .fifo_data(fifo_data),
    .fifo_valid(fifo_valid), .fifo_count(fifo_count), .fifo_ready(fifo_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .tx_done(tx_done)
  );

  logic [7:0] mem [0:255];
  logic [7:0] rd = 8'd0, wr = 8'd0;
  assign fifo_data  = mem[rd];
  assign fifo_count = wr - rd;
  assign fifo_valid = (wr != rd);

  int n_cmp = 0, n_bad = 0;
  logic [7:0] rx [0:4095];
  int  rx_n = 0;
  bit  done_seen = 0;
  int  done_at = 0;
  bit  pop_flag = 0, prev_stall = 0, rand_ready = 0;
  logic [7:0] prev_data = 8'h00;
  logic [7:0] pay [0:300];
  int  pay_n;
  logic [7:0] ex [0:400];
  int  ex_n;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rand_ready) out_ready = ($urandom % 10) < 7;
    #1;
    if (rst_n) begin
      if (prev_stall) chk(out_valid && out_data == prev_data, "R10", "stalled byte held", int'(out_data), int'(prev_data));
      if (tx_done && !done_seen) begin done_seen = 1; done_at = rx_n; end
      if (out_valid && out_ready && rx_n < 4096) begin rx[rx_n] = out_data; rx_n++; end
      pop_flag   = fifo_ready && fifo_valid;
      prev_stall = out_valid && !out_ready && tx_mode;
      prev_data  = out_data;
    end else begin
      pop_flag = 0; prev_stall = 0;
    end
  end

  always @(posedge clk) if (pop_flag) rd <= rd + 8'd1;

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {pay[i], 8'h00};
      for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [8:0] ref_pn9(input logic [8:0] s);
    logic [8:0] r = s;
    for (int b = 0; b < 8; b++) begin
      logic nb;
      nb = r[0] ^ r[5];
      r = (r >> 1) | ({8'h00, nb} << 8);
    end
    return r;
  endfunction

  task automatic build_expect();
    logic [8:0] w = 9'h1FF;
    logic [15:0] c;
    ex_n = 0;
    for (int k = 0; k <= int'(sync_sz); k++) begin ex[ex_n] = sync_word[31-8*k -: 8]; ex_n++; end
    for (int i = 0; i < pay_n; i++) begin
      ex[ex_n] = pay[i] ^ (white_en ? w[7:0] : 8'h00); ex_n++; w = ref_pn9(w);
    end
    if (crc_en) begin
      c = ref_crc(pay_n);
      ex[ex_n] = c[15:8] ^ (white_en ? w[7:0] : 8'h00); ex_n++; w = ref_pn9(w);
      ex[ex_n] = c[7:0]  ^ (white_en ? w[7:0] : 8'h00); ex_n++;
    end
  endtask

  task automatic push(input logic [7:0] b);
    mem[wr] = b; wr = wr + 8'd1;
  endtask

  // one packet: prefill or fed during TX mode, then stream checks
  task automatic run_pkt(input bit prefill, input int hold_back, input int gap);
    int lead, ok, tail_ok, tail_n, pushed;
    @(negedge clk);
    tx_mode = 1'b0; rd <= 8'd0; wr = 8'd0;
    @(negedge clk);
    rx_n = 0; done_seen = 0; pushed = 0;
    if (prefill) begin
      for (int i = 0; i < pay_n; i++) push(pay[i]);
      push(8'h5A); pushed = pay_n + 1;
      repeat (5) @(negedge clk);
      chk(!out_valid && !fifo_ready && !tx_done && rd == 8'd0, "R1", "idle with full fifo", int'(rd), 0);
    end
    tx_mode = 1'b1;
    if (!prefill) begin
      for (int i = 0; i < hold_back; i++) begin push(pay[i]); pushed++; end
      repeat (12) @(negedge clk);
      ok = (rx_n > 0);
      for (int i = 0; i < rx_n; i++) if (rx[i] != 8'hAA) ok = 0;
      chk(ok == 1 && rd == 8'd0, "R2", "filler while waiting (R3 gate)", int'(rd), 0);
      while (pushed < pay_n + 1) begin
        push(pushed < pay_n ? pay[pushed] : 8'h5A); pushed++;
        repeat (gap) @(negedge clk);
      end
    end
    for (int t = 0; t < 3000 && !done_seen; t++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(tx_done == 1'b1, "R9", "done held in tx mode", int'(tx_done), 1);
    build_expect();
    lead = 0;
    while (lead < rx_n && rx[lead] == 8'hAA) lead++;
    if (prefill) chk(lead == int'(pre_len) + 1, "R4", "0xAA count before sync", lead, int'(pre_len) + 1);
    else chk(lead >= int'(pre_len) + 1, "R4", "0xAA count before sync", lead, int'(pre_len) + 1);
    ok = 1;
    for (int i = 0; i < ex_n; i++) if (lead + i >= rx_n || rx[lead + i] != ex[i]) ok = 0;
    chk(ok == 1, "R5", "sync/payload R6/crc R7/whiten R8 bytes", rx[lead + ex_n - 1], ex[ex_n - 1]);
    chk(done_seen && done_at == lead + ex_n, "R9", "done position", done_at, lead + ex_n);
    tail_ok = 1; tail_n = 0;
    for (int i = lead + ex_n; i < rx_n; i++) begin tail_n++; if (rx[i] != 8'hAA) tail_ok = 0; end
    chk(tail_ok == 1 && tail_n > 0, "R9", "filler after done", tail_n, 1);
    chk(fifo_count == 8'd1 && fifo_data == 8'h5A, "R6", "bytes left in fifo", int'(fifo_count), 1);
    tx_mode = 1'b0;
    repeat (2) @(negedge clk);
    chk(!out_valid && !tx_done && !fifo_ready, "R11", "idle after leaving", int'(tx_done), 0);
  endtask

  task automatic make_payload(input int len_or_l);
    if (var_len) begin
      pay[0] = 8'(len_or_l); pay_n = len_or_l + 1;
      for (int i = 1; i < pay_n; i++) pay[i] = 8'($urandom);
    end else begin
      pay_n = (fixed_len == 8'd0) ? 256 : int'(fixed_len);
      for (int i = 0; i < pay_n; i++) pay[i] = 8'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!out_valid && !tx_done && !fifo_ready, "R1", "reset state", int'(out_valid), 0);
    rst_n = 1'b1;

    // fixed length, crc, no whitening, prefilled
    start_any = 1; pre_len = 3; sync_sz = 1; sync_word = 32'h2DD4_0000;
    var_len = 0; fixed_len = 6; crc_en = 1; white_en = 0;
    make_payload(0); run_pkt(1, 0, 0);

    // variable length with whitening, no preamble, 4-byte sync
    pre_len = 0; sync_sz = 3; sync_word = 32'hC1A5_3C96;
    var_len = 1; crc_en = 1; white_en = 1;
    make_payload(9); run_pkt(1, 0, 0);

    // threshold start, no crc, fed during tx mode (R3)
    start_any = 0; start_level = 5; pre_len = 2; sync_sz = 0; sync_word = 32'h7E00_0000;
    var_len = 0; fixed_len = 8; crc_en = 0; white_en = 0;
    make_payload(0); run_pkt(0, 4, 1);

    // one-byte start, length byte zero, slow feeding with back-pressure
    rand_ready = 1;
    start_any = 1; pre_len = 1; sync_sz = 2; sync_word = 32'h1122_3344;
    var_len = 1; crc_en = 1; white_en = 1;
    make_payload(0); run_pkt(0, 0, 3);
    make_payload(12); run_pkt(0, 0, 4);

    for (int it = 0; it < 8; it++) begin
      int tot;
      pre_len = 8'($urandom % 6); sync_sz = 2'($urandom);
      sync_word = $urandom; if (sync_word[31:24] == 8'hAA) sync_word[31:24] = 8'h55;
      var_len = 1'($urandom); fixed_len = 8'(1 + $urandom % 16);
      crc_en = 1'($urandom); white_en = 1'($urandom); start_any = 1'($urandom);
      make_payload($urandom % 16);
      tot = pay_n + 1;
      start_level = 8'(1 + $urandom % ((tot < 6) ? tot : 6));
      run_pkt(1'($urandom), 0, $urandom % 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule